// File: doc/BRIEF.md
# Address Window Remapping Unit

This block sits on the address side of a 32-bit processor bus and redirects fetch and load addresses that fall in programmable windows. Software sets each window with an inclusive lower bound, an inclusive upper bound, a target base and a backing size. The backing size is given as a power-of-two exponent. An address inside an enabled window is sent to the target base plus its offset into the window, reduced modulo the backing size. A window larger than its backing region therefore repeats the same backing contents. A typical use relocates the exception vectors in the first 4 KB onto RAM.

Only addresses below 0x0080_0000 can be remapped. Addresses at or above that bound, and addresses that no enabled window covers, pass through unchanged with the hit flag low. A window is live only when its own enable bit and the enable bit of its group are both set in the control register. When live windows overlap, the lowest-numbered one wins. Each request produces its result one clock later.

Top module: `amr_remap_top`

## Requirements
- R1: After reset, every register reads zero, and rsp_valid_o and rsp_hit_o are low.
- R2: The control register sits at byte offset 0x00. Window w has its registers at 0x20+0x10*w: lower bound at +0x0, upper bound at +0x4, target base at +0x8 and size exponent at +0xC. A write followed by a read returns the value written, with these exceptions. The size exponent keeps only bits [4:0]. The control register keeps only bits [NUM_WIN-1:0] and [11:8], so writing all ones to it reads back 0x0000_0FFF when there are 8 windows.
- R3: Bounds are inclusive. An address equal to the lower bound or to the upper bound hits. The address one below the lower bound misses, and so does the address one above the upper bound.
- R4: On a hit, rsp_addr_o equals target + ((addr − lower) mod 2^size) and rsp_hit_o is high.
- R5: Offsets at or beyond 2^size wrap, so addresses a multiple of 2^size apart inside one window translate to the same result.
- R6: A request address at or above 0x0080_0000 never hits, even when a window covers it.
- R7: Window w is live only when control bit w and control bit 8+w/(NUM_WIN/4) are both set. Either bit alone leaves the window off.
- R8: When several live windows contain the address, the lowest-numbered one decides the translation.
- R9: On a miss, rsp_addr_o equals the request address and rsp_hit_o is low.
- R10: rsp_valid_o, rsp_addr_o and rsp_hit_o reflect the request presented one clock earlier. rsp_valid_o is low in the cycle after a cycle with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| arst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 8 | Register byte offset |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_rdata_o | output | 32 | Register read data for cfg_addr_i (combinational) |
| req_valid_i | input | 1 | Address request valid |
| req_addr_i | input | 32 | Address to translate |
| rsp_valid_o | output | 1 | Result valid, one cycle after the request |
| rsp_addr_o | output | 32 | Translated or passed-through address |
| rsp_hit_o | output | 1 | High when a live window translated the address |

## Verification
The hardest case to reach from the ports is a window that straddles the 8 MB bound. The bench has to show that the address just below the bound is translated with its full wrapped offset, while the address exactly at the bound is passed through untouched. To get there, a window is programmed to span the bound, with a backing size smaller than its length. Requests are then sent at 0x007F_FFFF, at 0x0080_0000 and at the window's top. Overlap priority is handled the same way. Two windows are programmed over the same range, and the lower-numbered one is switched off through its own enable bit so that the other takes over.

// File: rtl/amr_pkg.sv
package amr_pkg;

  localparam int unsigned AW = 32;
  localparam int unsigned SIZE_W = 5;
  localparam int unsigned NUM_GRP = 4;
  localparam int unsigned GRP_BIT0 = 8;
  localparam logic [AW-1:0] REMAP_LIMIT = 32'h0080_0000;

  typedef struct packed {
    logic [AW-1:0]     lower;
    logic [AW-1:0]     upper;
    logic [AW-1:0]     target;
    logic [SIZE_W-1:0] size_log2;
  } win_cfg_t;

  typedef enum logic [1:0] {
    FLD_LOWER  = 2'd0,
    FLD_UPPER  = 2'd1,
    FLD_TARGET = 2'd2,
    FLD_SIZE   = 2'd3
  } win_fld_e;

endpackage

// File: rtl/amr_regfile.sv
module amr_regfile
  import amr_pkg::*;
#(
  parameter int unsigned NUM_WIN = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [7:0]               addr_i,
  input  logic [AW-1:0]            wdata_i,
  output logic [AW-1:0]            rdata_o,
  output win_cfg_t [NUM_WIN-1:0]   cfg_o,
  output logic [NUM_WIN-1:0]       live_o
);

  localparam int unsigned GRP_SIZE = NUM_WIN / NUM_GRP;
  localparam logic [AW-1:0] WIN_MASK = AW'((64'd1 << NUM_WIN) - 64'd1);
  localparam logic [AW-1:0] CTRL_MASK = WIN_MASK | (AW'(4'hF) << GRP_BIT0);

  win_cfg_t [NUM_WIN-1:0] cfg_q, cfg_d;
  logic [AW-1:0]          ctrl_q, ctrl_d;

  logic       aligned;
  logic       is_ctrl;
  logic       is_win;
  logic [3:0] slot;
  logic [3:0] widx;
  win_fld_e   fld;

  assign aligned = (addr_i[1:0] == 2'b00);
  assign slot    = addr_i[7:4];
  assign widx    = slot - 4'd2;
  assign fld     = win_fld_e'(addr_i[3:2]);
  assign is_ctrl = aligned && (addr_i[7:2] == 6'd0);
  assign is_win  = aligned && (slot >= 4'd2) && (32'(widx) < NUM_WIN);

  // next-state
  always_comb begin
    cfg_d  = cfg_q;
    ctrl_d = ctrl_q;
    if (we_i) begin
      if (is_ctrl) begin
        ctrl_d = wdata_i & CTRL_MASK;
      end
      for (int w = 0; w < NUM_WIN; w++) begin
        if (is_win && (32'(widx) == w)) begin
          case (fld)
            FLD_LOWER:  cfg_d[w].lower     = wdata_i;
            FLD_UPPER:  cfg_d[w].upper     = wdata_i;
            FLD_TARGET: cfg_d[w].target    = wdata_i;
            default:    cfg_d[w].size_log2 = wdata_i[SIZE_W-1:0];
          endcase
        end
      end
    end
  end

  // registers, clock-enabled by the write strobe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      ctrl_q <= '0;
    end else if (we_i) begin
      cfg_q  <= cfg_d;
      ctrl_q <= ctrl_d;
    end
  end

  // read mux
  always_comb begin
    rdata_o = '0;
    if (is_ctrl) begin
      rdata_o = ctrl_q;
    end
    for (int w = 0; w < NUM_WIN; w++) begin
      if (is_win && (32'(widx) == w)) begin
        case (fld)
          FLD_LOWER:  rdata_o = cfg_q[w].lower;
          FLD_UPPER:  rdata_o = cfg_q[w].upper;
          FLD_TARGET: rdata_o = cfg_q[w].target;
          default:    rdata_o = {{(AW-SIZE_W){1'b0}}, cfg_q[w].size_log2};
        endcase
      end
    end
  end

  assign cfg_o = cfg_q;

  // a window is live when its own bit and its group bit are set
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_live
    assign live_o[w] = ctrl_q[w] & ctrl_q[GRP_BIT0 + w / GRP_SIZE];
  end

endmodule

// File: rtl/amr_win_match.sv
module amr_win_match
  import amr_pkg::*;
(
  input  logic [AW-1:0] addr_i,
  input  win_cfg_t      cfg_i,
  input  logic          live_i,
  output logic          hit_o,
  output logic [AW-1:0] xlat_o
);

  logic          below_limit;
  logic          in_range;
  logic [AW-1:0] offset;
  logic [AW-1:0] size_mask;

  assign below_limit = (addr_i < REMAP_LIMIT);
  assign in_range    = (addr_i >= cfg_i.lower) && (addr_i <= cfg_i.upper);
  assign hit_o       = live_i && below_limit && in_range;

  assign offset    = addr_i - cfg_i.lower;
  assign size_mask = (AW'(1) << cfg_i.size_log2) - AW'(1);
  assign xlat_o    = cfg_i.target + (offset & size_mask);

endmodule

// File: rtl/amr_prio_sel.sv
module amr_prio_sel
  import amr_pkg::*;
#(
  parameter int unsigned NUM_WIN = 8
) (
  input  logic [NUM_WIN-1:0]         hit_i,
  input  logic [NUM_WIN-1:0][AW-1:0] xlat_i,
  output logic                       any_o,
  output logic [NUM_WIN-1:0]         sel_oh_o,
  output logic [AW-1:0]              addr_o
);

  // scan from the top so the lowest-numbered hit is the last one kept
  always_comb begin
    any_o    = 1'b0;
    sel_oh_o = '0;
    addr_o   = '0;
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (hit_i[w]) begin
        any_o       = 1'b1;
        sel_oh_o    = '0;
        sel_oh_o[w] = 1'b1;
        addr_o      = xlat_i[w];
      end
    end
  end

endmodule

// File: rtl/amr_remap_top.sv
module amr_remap_top
  import amr_pkg::*;
#(
  parameter int unsigned NUM_WIN = 8
) (
  input  logic          clk_i,
  input  logic          arst_ni,
  input  logic          cfg_we_i,
  input  logic [7:0]    cfg_addr_i,
  input  logic [31:0]   cfg_wdata_i,
  output logic [31:0]   cfg_rdata_o,
  input  logic          req_valid_i,
  input  logic [31:0]   req_addr_i,
  output logic          rsp_valid_o,
  output logic [31:0]   rsp_addr_o,
  output logic          rsp_hit_o
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_sync_q[1];

  win_cfg_t [NUM_WIN-1:0]     win_cfg;
  logic [NUM_WIN-1:0]         win_live;
  logic [NUM_WIN-1:0]         win_hit;
  logic [NUM_WIN-1:0][AW-1:0] win_xlat;
  logic [NUM_WIN-1:0]         win_sel_oh;
  logic                       any_hit;
  logic [AW-1:0]              sel_addr;

  amr_regfile #(.NUM_WIN(NUM_WIN)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .rdata_o (cfg_rdata_o),
    .cfg_o   (win_cfg),
    .live_o  (win_live)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    amr_win_match u_match (
      .addr_i (req_addr_i),
      .cfg_i  (win_cfg[w]),
      .live_i (win_live[w]),
      .hit_o  (win_hit[w]),
      .xlat_o (win_xlat[w])
    );
  end

  amr_prio_sel #(.NUM_WIN(NUM_WIN)) u_sel (
    .hit_i    (win_hit),
    .xlat_i   (win_xlat),
    .any_o    (any_hit),
    .sel_oh_o (win_sel_oh),
    .addr_o   (sel_addr)
  );

  // output stage
  logic          valid_q, valid_d;
  logic          hit_q, hit_d;
  logic [AW-1:0] addr_q, addr_d;

  always_comb begin
    valid_d = req_valid_i;
    hit_d   = req_valid_i & any_hit;
    addr_d  = any_hit ? sel_addr : req_addr_i;
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= 1'b0;
      hit_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      hit_q   <= hit_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      addr_q <= '0;
    end else if (req_valid_i) begin
      addr_q <= addr_d;
    end
  end

  assign rsp_valid_o = valid_q;
  assign rsp_hit_o   = hit_q;
  assign rsp_addr_o  = addr_q;

endmodule

// File: rtl/amr_remap_chk.sv
module amr_remap_chk
  import amr_pkg::*;
#(
  parameter int unsigned NUM_WIN = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_valid_i,
  input logic [31:0]        req_addr_i,
  input logic               rsp_valid_o,
  input logic [31:0]        rsp_addr_o,
  input logic               rsp_hit_o,
  input logic [NUM_WIN-1:0] sel_oh
);

  assert_valid_follows_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);

  assert_limit_pass_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && (req_addr_i >= REMAP_LIMIT)) |=>
      (!rsp_hit_o && (rsp_addr_o == $past(req_addr_i))));

  assert_miss_pass_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (rsp_hit_o || (rsp_addr_o == $past(req_addr_i))));

  assert_hit_valid_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_hit_o |-> rsp_valid_o);

  assert_single_grant_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_oh));

endmodule

bind amr_remap_top amr_remap_chk #(.NUM_WIN(NUM_WIN)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_sync_n),
  .req_valid_i (req_valid_i),
  .req_addr_i  (req_addr_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_addr_o  (rsp_addr_o),
  .rsp_hit_o   (rsp_hit_o),
  .sel_oh      (win_sel_oh)
);

// File: tb/tb_amr_remap_top.sv
`timescale 1ns/1ps
module tb_amr_remap_top;

  logic        clk_i = 1'b0;
  logic        arst_ni;
  logic        cfg_we_i;
  logic [7:0]  cfg_addr_i;
  logic [31:0] cfg_wdata_i;
  logic [31:0] cfg_rdata_o;
  logic        req_valid_i;
  logic [31:0] req_addr_i;
  logic        rsp_valid_o;
  logic [31:0] rsp_addr_o;
  logic        rsp_hit_o;

  int checks = 0;
  int fails  = 0;

  always #4 clk_i = ~clk_i;

  amr_remap_top #(.NUM_WIN(8)) dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [7:0] a, input logic [31:0] exp);
    cfg_addr_i = a;
    #1;
    check(req, cfg_rdata_o, exp);
  endtask

  task automatic set_win(input int w, input logic [31:0] lo, input logic [31:0] hi,
                         input logic [31:0] tgt, input logic [31:0] sz);
    logic [7:0] base;
    base = 8'(8'h20 + 8'h10 * w);
    wr(base, lo);
    wr(base + 8'h4, hi);
    wr(base + 8'h8, tgt);
    wr(base + 8'hC, sz);
  endtask

  // one request; result sampled at the next falling edge
  task automatic xlat(input string req, input logic [31:0] a,
                      input logic [31:0] exp_addr, input logic exp_hit);
    req_valid_i = 1'b1; req_addr_i = a;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    check({req, " valid"}, {31'd0, rsp_valid_o}, 32'd1);
    check({req, " hit"}, {31'd0, rsp_hit_o}, {31'd0, exp_hit});
    check({req, " addr"}, rsp_addr_o, exp_addr);
  endtask

  task automatic t_reset;
    check("R1 rsp_valid", {31'd0, rsp_valid_o}, 32'd0);
    check("R1 rsp_hit", {31'd0, rsp_hit_o}, 32'd0);
    rd_check("R1 ctrl", 8'h00, 32'h0);
    rd_check("R1 win0 lower", 8'h20, 32'h0);
    rd_check("R1 win7 size", 8'h9C, 32'h0);
    xlat("R9 passthrough after reset", 32'h0000_0100, 32'h0000_0100, 1'b0);
  endtask

  task automatic t_regs;
    wr(8'h30, 32'h1234_5678);
    rd_check("R2 win1 lower", 8'h30, 32'h1234_5678);
    wr(8'h38, 32'hCAFE_0000);
    rd_check("R2 win1 target", 8'h38, 32'hCAFE_0000);
    wr(8'h3C, 32'hFFFF_FFE7);
    rd_check("R2 win1 size", 8'h3C, 32'h0000_0007);
    wr(8'h00, 32'hFFFF_FFFF);
    rd_check("R2 ctrl mask", 8'h00, 32'h0000_0FFF);
    wr(8'h00, 32'h0);
  endtask

  task automatic t_vector;
    set_win(0, 32'h0, 32'h0000_0FFF, 32'h0200_0000, 32'd12);
    wr(8'h00, 32'h0000_0101);
    xlat("R4 vector relocate", 32'h0000_0018, 32'h0200_0018, 1'b1);
    wr(8'h00, 32'h0);
  endtask

  task automatic t_bounds;
    set_win(2, 32'h0000_1000, 32'h0000_1FFF, 32'h0040_0000, 32'd12);
    wr(8'h00, 32'h0000_0204);
    xlat("R3 lower bound", 32'h0000_1000, 32'h0040_0000, 1'b1);
    xlat("R3 upper bound", 32'h0000_1FFF, 32'h0040_0FFF, 1'b1);
    xlat("R3 below lower", 32'h0000_0FFF, 32'h0000_0FFF, 1'b0);
    xlat("R3 above upper", 32'h0000_2000, 32'h0000_2000, 1'b0);
    wr(8'h00, 32'h0);
  endtask

  task automatic t_wrap;
    set_win(3, 32'h0001_0000, 32'h0001_3FFF, 32'h0005_0000, 32'd10);
    wr(8'h00, 32'h0000_0208);
    xlat("R5 wrap one period", 32'h0001_0400, 32'h0005_0000, 1'b1);
    xlat("R5 wrap three periods", 32'h0001_0BFC, 32'h0005_03FC, 1'b1);
    xlat("R4 inside first period", 32'h0001_0010, 32'h0005_0010, 1'b1);
    wr(8'h00, 32'h0);
  endtask

  task automatic t_limit;
    set_win(4, 32'h0070_0000, 32'h00FF_FFFF, 32'h0000_0100, 32'd20);
    wr(8'h00, 32'h0000_0410);
    xlat("R6 just below limit", 32'h007F_FFFF, 32'h0010_00FF, 1'b1);
    xlat("R6 at limit", 32'h0080_0000, 32'h0080_0000, 1'b0);
    xlat("R6 window top", 32'h00FF_FFFF, 32'h00FF_FFFF, 1'b0);
    wr(8'h00, 32'h0);
  endtask

  task automatic t_enable;
    set_win(5, 32'h0000_2000, 32'h0000_2FFF, 32'h0000_9000, 32'd12);
    wr(8'h00, 32'h0000_0020);
    xlat("R7 own bit only", 32'h0000_2010, 32'h0000_2010, 1'b0);
    wr(8'h00, 32'h0000_0400);
    xlat("R7 group bit only", 32'h0000_2010, 32'h0000_2010, 1'b0);
    wr(8'h00, 32'h0000_0420);
    xlat("R7 both bits", 32'h0000_2010, 32'h0000_9010, 1'b1);
    wr(8'h00, 32'h0);
  endtask

  task automatic t_prio;
    set_win(6, 32'h0000_3000, 32'h0000_3FFF, 32'h0000_A000, 32'd12);
    set_win(7, 32'h0000_3000, 32'h0000_3FFF, 32'h0000_B000, 32'd12);
    wr(8'h00, 32'h0000_08C0);
    xlat("R8 lower index wins", 32'h0000_3004, 32'h0000_A004, 1'b1);
    wr(8'h00, 32'h0000_0880);
    xlat("R8 next window takes over", 32'h0000_3004, 32'h0000_B004, 1'b1);
    wr(8'h00, 32'h0);
  endtask

  task automatic t_latency;
    xlat("R10 request", 32'h0000_3004, 32'h0000_3004, 1'b0);
    @(negedge clk_i);
    check("R10 idle valid", {31'd0, rsp_valid_o}, 32'd0);
    check("R10 idle hit", {31'd0, rsp_hit_o}, 32'd0);
  endtask

  initial begin
    arst_ni = 1'b0; cfg_we_i = 1'b0; cfg_addr_i = '0; cfg_wdata_i = '0;
    req_valid_i = 1'b0; req_addr_i = '0;
    repeat (3) @(negedge clk_i);
    arst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    t_reset();
    t_regs();
    t_vector();
    t_bounds();
    t_wrap();
    t_limit();
    t_enable();
    t_prio();
    t_latency();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule